// File: doc/BRIEF.md
# Processor Power Mode Controller

This block governs the power state of a processor core. It supports four states: Full On, Doze, Nap and Sleep. Software first places a 2-bit target code on `mode_sel` and then pulses `enter_req`. If the controller is in Full On, it moves to the chosen low-power state on the next clock edge. Each low-power state keeps a different set of services alive, so each state also accepts a different set of wake events. Doze keeps bus snooping and the decrementer running. Nap keeps only the decrementer. Sleep stops everything. Every wake event returns the controller to Full On.

Inside Full On there is also dynamic per-unit clock gating, controlled by one configuration bit. When the bit is set, the clock enable of each execution unit follows that unit's busy flag, so an idle unit gets no clock. When the bit is clear, every unit runs. The clock gating cells and the interrupt controller sit outside this block.

State names and transitions: FULL_ON to DOZE, NAP or SLEEP on an entry request with code 01, 10 or 11. DOZE to FULL_ON on an external or decrementer interrupt. NAP to FULL_ON on an external or decrementer interrupt. SLEEP to FULL_ON on an external interrupt only. Any state goes to FULL_ON on reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the state is Full On (`state_o` = 0), dynamic gating is disabled, every `unit_clk_en` bit is 1, and `snoop_en` and `dec_en` are 1.
- R2: In Full On with dynamic gating disabled, every `unit_clk_en` bit is 1 whatever `unit_busy` holds.
- R3: In Full On with dynamic gating enabled, `unit_clk_en[i]` equals `unit_busy[i]` in the same cycle.
- R4: A cycle with `cfg_wr` high loads `cfg_dyn_en` into the dynamic gating bit. The new value governs the enables from the next clock edge onward.
- R5: In Full On, `enter_req` with `mode_sel` 01, 10 or 11 moves the state at the next edge to Doze (`state_o` = 1), Nap (2) or Sleep (3). With `mode_sel` = 00 the request is ignored and the state stays Full On.
- R6: In Doze, `snoop_en` = 1, `dec_en` = 1 and all `unit_clk_en` bits are 0.
- R7: In Nap, `snoop_en` = 0, `dec_en` = 1 and all `unit_clk_en` bits are 0.
- R8: In Sleep, `snoop_en`, `dec_en` and all `unit_clk_en` bits are 0.
- R9: In Doze or Nap, a high `ext_irq` or `dec_irq` returns the state to Full On at the next edge.
- R10: In Sleep, only `ext_irq` wakes the controller. A `dec_irq` alone leaves it in Sleep.
- R11: An `enter_req` made while a low-power state is active, with no wake event present, leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the dynamic gating bit |
| cfg_dyn_en | input | 1 | Value written to the dynamic gating bit |
| mode_sel | input | 2 | Target mode: 01 Doze, 10 Nap, 11 Sleep, 00 none |
| enter_req | input | 1 | Request to enter the selected mode |
| ext_irq | input | 1 | External interrupt wake event |
| dec_irq | input | 1 | Decrementer interrupt wake event |
| unit_busy | input | NUM_UNITS | Per-unit pending-work flags |
| unit_clk_en | output | NUM_UNITS | Per-unit clock enables |
| snoop_en | output | 1 | Bus snooping enable |
| dec_en | output | 1 | Decrementer enable |
| state_o | output | 2 | Current state: 0 Full On, 1 Doze, 2 Nap, 3 Sleep |

## Verification
A wrong state register shows up on `state_o` and on the snoop and decrementer enables in the cycle right after the edge that stored it, because all three are decoded directly from the state. A wrong dynamic gating bit appears in `unit_clk_en` one edge after the write, and only while the controller is in Full On with some units idle. For that reason the vectors toggle `unit_busy` patterns with the bit both set and clear. Wake filtering faults, such as Sleep reacting to the decrementer, show up as a premature return to state 0 on the next edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        ST_FULL_ON = 2'd0,
        ST_DOZE    = 2'd1,
        ST_NAP     = 2'd2,
        ST_SLEEP   = 2'd3
    } pmc_state_e;

    localparam logic [1:0] MODE_NONE  = 2'd0;
    localparam logic [1:0] MODE_DOZE  = 2'd1;
    localparam logic [1:0] MODE_NAP   = 2'd2;
    localparam logic [1:0] MODE_SLEEP = 2'd3;
endpackage

// File: rtl/pmc_cfg_reg.sv
module pmc_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wdata,
    output logic dyn_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dyn_q <= 1'b0;
        end else if (wr) begin
            dyn_q <= wdata;
        end
    end
endmodule

// File: rtl/pmc_wake.sv
module pmc_wake
    import pmc_pkg::*;
(
    input  pmc_state_e state,
    input  logic       ext_irq,
    input  logic       dec_irq,
    output logic       wake
);
    // The set of services kept alive decides which events can wake a state.
    always_comb begin
        unique case (state)
            ST_FULL_ON: wake = 1'b0;
            ST_DOZE:    wake = ext_irq | dec_irq;
            ST_NAP:     wake = ext_irq | dec_irq;
            ST_SLEEP:   wake = ext_irq;
            default:    wake = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_req,
    input  logic [1:0] mode_sel,
    input  logic       wake,
    output pmc_state_e state_q,
    output logic       units_allowed,
    output logic       snoop_en,
    output logic       dec_en
);
    pmc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FULL_ON: begin
                if (enter_req) begin
                    unique case (mode_sel)
                        MODE_DOZE:  state_d = ST_DOZE;
                        MODE_NAP:   state_d = ST_NAP;
                        MODE_SLEEP: state_d = ST_SLEEP;
                        default:    state_d = ST_FULL_ON;
                    endcase
                end
            end
            ST_DOZE, ST_NAP, ST_SLEEP: begin
                if (wake) begin
                    state_d = ST_FULL_ON;
                end
            end
            default: state_d = ST_FULL_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FULL_ON;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FULL_ON: begin
                units_allowed = 1'b1;
                snoop_en      = 1'b1;
                dec_en        = 1'b1;
            end
            ST_DOZE: begin
                units_allowed = 1'b0;
                snoop_en      = 1'b1;
                dec_en        = 1'b1;
            end
            ST_NAP: begin
                units_allowed = 1'b0;
                snoop_en      = 1'b0;
                dec_en        = 1'b1;
            end
            ST_SLEEP: begin
                units_allowed = 1'b0;
                snoop_en      = 1'b0;
                dec_en        = 1'b0;
            end
            default: begin
                units_allowed = 1'b1;
                snoop_en      = 1'b1;
                dec_en        = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pmc_unit_gate.sv
module pmc_unit_gate #(
    parameter int NUM_UNITS = 5
) (
    input  logic                 units_allowed,
    input  logic                 dyn_en,
    input  logic [NUM_UNITS-1:0] busy,
    output logic [NUM_UNITS-1:0] clk_en
);
    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        assign clk_en[i] = units_allowed & (~dyn_en | busy[i]);
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NUM_UNITS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 cfg_dyn_en,
    input  logic [1:0]           mode_sel,
    input  logic                 enter_req,
    input  logic                 ext_irq,
    input  logic                 dec_irq,
    input  logic [NUM_UNITS-1:0] unit_busy,
    output logic [NUM_UNITS-1:0] unit_clk_en,
    output logic                 snoop_en,
    output logic                 dec_en,
    output logic [1:0]           state_o
);
    pmc_state_e state_q;
    logic       dyn_q;
    logic       wake;
    logic       units_allowed;

    pmc_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_dyn_en),
        .dyn_q (dyn_q)
    );

    pmc_wake u_wake (
        .state   (state_q),
        .ext_irq (ext_irq),
        .dec_irq (dec_irq),
        .wake    (wake)
    );

    pmc_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enter_req     (enter_req),
        .mode_sel      (mode_sel),
        .wake          (wake),
        .state_q       (state_q),
        .units_allowed (units_allowed),
        .snoop_en      (snoop_en),
        .dec_en        (dec_en)
    );

    pmc_unit_gate #(.NUM_UNITS(NUM_UNITS)) u_gate (
        .units_allowed (units_allowed),
        .dyn_en        (dyn_q),
        .busy          (unit_busy),
        .clk_en        (unit_clk_en)
    );

    assign state_o = state_q;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int NUM_UNITS = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dyn_q,
    input logic [1:0]           mode_sel,
    input logic                 enter_req,
    input logic                 ext_irq,
    input logic                 dec_irq,
    input logic [NUM_UNITS-1:0] unit_busy,
    input logic [NUM_UNITS-1:0] unit_clk_en,
    input logic                 snoop_en,
    input logic                 dec_en,
    input logic [1:0]           state_o
);
    assert_full_nodyn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && !dyn_q) |-> (&unit_clk_en));

    assert_full_dyn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && dyn_q) |-> (unit_clk_en == unit_busy));

    assert_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && enter_req) |=> (state_o == $past(mode_sel)));

    assert_doze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |-> (snoop_en && dec_en && unit_clk_en == '0));

    assert_nap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |-> (!snoop_en && dec_en && unit_clk_en == '0));

    assert_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3) |-> (!snoop_en && !dec_en && unit_clk_en == '0));

    assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 2'd1 || state_o == 2'd2) && (ext_irq || dec_irq)) |=> (state_o == 2'd0));

    assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && !ext_irq) |=> (state_o == 2'd3));

    assert_no_reentry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd0 && !ext_irq && !dec_irq) |=> $stable(state_o));
endmodule

bind pwr_mode_ctrl pmc_checker #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dyn_q       (dyn_q),
    .mode_sel    (mode_sel),
    .enter_req   (enter_req),
    .ext_irq     (ext_irq),
    .dec_irq     (dec_irq),
    .unit_busy   (unit_busy),
    .unit_clk_en (unit_clk_en),
    .snoop_en    (snoop_en),
    .dec_en      (dec_en),
    .state_o     (state_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic         cfg_dyn_en = 1'b0;
    logic [1:0]   mode_sel = 2'd0;
    logic         enter_req = 1'b0;
    logic         ext_irq = 1'b0;
    logic         dec_irq = 1'b0;
    logic [N-1:0] unit_busy = '0;
    logic [N-1:0] unit_clk_en;
    logic         snoop_en;
    logic         dec_en;
    logic [1:0]   state_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pwr_mode_ctrl #(.NUM_UNITS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dyn_en(cfg_dyn_en),
        .mode_sel(mode_sel), .enter_req(enter_req), .ext_irq(ext_irq),
        .dec_irq(dec_irq), .unit_busy(unit_busy), .unit_clk_en(unit_clk_en),
        .snoop_en(snoop_en), .dec_en(dec_en), .state_o(state_o)
    );

    typedef struct packed {
        logic [1:0]   mode;
        logic         enter;
        logic         ext;
        logic         dec;
        logic         cw;
        logic         cv;
        logic [N-1:0] busy;
        logic [1:0]   e_state;
        logic         e_snoop;
        logic         e_dec;
        logic [N-1:0] e_clk;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        // mode enter ext dec cw cv busy     state snoop dec clk
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b01010, 2'd0, 1'b1, 1'b1, 5'b11111}, // R2
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'b00101, 2'd0, 1'b1, 1'b1, 5'b00101}, // R4 R3
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b10010, 2'd0, 1'b1, 1'b1, 5'b10010}, // R3
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b11111, 2'd1, 1'b1, 1'b1, 5'b00000}, // R5 R6
        '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b11111, 2'd1, 1'b1, 1'b1, 5'b00000}, // R11
        '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'b00001, 2'd0, 1'b1, 1'b1, 5'b00001}, // R9 dec wakes doze
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 2'd2, 1'b0, 1'b1, 5'b00000}, // R5 R7
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 2'd2, 1'b0, 1'b1, 5'b00000}, // R11
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b01100, 2'd0, 1'b1, 1'b1, 5'b01100}, // R9 ext wakes nap
        '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b11111, 2'd3, 1'b0, 1'b0, 5'b00000}, // R5 R8
        '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'b11111, 2'd3, 1'b0, 1'b0, 5'b00000}, // R10 dec ignored
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b10000, 2'd0, 1'b1, 1'b1, 5'b10000}, // R10 ext wakes sleep
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 2'd0, 1'b1, 1'b1, 5'b00000}, // R5 code 00 ignored
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00000, 2'd0, 1'b1, 1'b1, 5'b11111}, // R4 R2
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 2'd2, 1'b0, 1'b1, 5'b00000}  // R7
    };

    task automatic check(input string req, input logic [1:0] st, input logic sn,
                         input logic de, input logic [N-1:0] ce);
        checks++;
        if (state_o !== st || snoop_en !== sn || dec_en !== de || unit_clk_en !== ce) begin
            failures++;
            $display("FAIL %s actual state=%0d snoop=%b dec=%b clk=%b expected state=%0d snoop=%b dec=%b clk=%b",
                     req, state_o, snoop_en, dec_en, unit_clk_en, st, sn, de, ce);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        mode_sel   = v.mode;
        enter_req  = v.enter;
        ext_irq    = v.ext;
        dec_irq    = v.dec;
        cfg_wr     = v.cw;
        cfg_dyn_en = v.cv;
        unit_busy  = v.busy;
        @(posedge clk);
        #2;
    endtask

    function automatic vec_t idle(input logic [N-1:0] b);
        vec_t v = '0;
        v.busy = b;
        return v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vec_t v;
        #3;
        check("R1 in reset", 2'd0, 1'b1, 1'b1, 5'b11111);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R1 after reset", 2'd0, 1'b1, 1'b1, 5'b11111);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            check($sformatf("R5-table row %0d", i), TBL[i].e_state, TBL[i].e_snoop,
                  TBL[i].e_dec, TBL[i].e_clk);
        end

        // Directed: dec_irq wakes Nap (R9), then dyn bit set before reset during Sleep (R1)
        v = idle('0);
        v.dec = 1'b1;
        drive(v);
        check("R9 dec wakes nap", 2'd0, 1'b1, 1'b1, 5'b11111);
        v = idle('0);
        v.cw = 1'b1;
        v.cv = 1'b1;
        drive(v);
        check("R4 dyn set idle units", 2'd0, 1'b1, 1'b1, 5'b00000);
        v = idle('0);
        v.enter = 1'b1;
        v.mode = 2'd3;
        drive(v);
        check("R8 sleep", 2'd3, 1'b0, 1'b0, 5'b00000);
        @(negedge clk);
        enter_req = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1 reset from sleep", 2'd0, 1'b1, 1'b1, 5'b11111);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R1 dyn cleared by reset", 2'd0, 1'b1, 1'b1, 5'b11111);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule